// File: doc/BRIEF.md
# Dual Peripheral Port Adapter

A two-port parallel peripheral adapter that sits on a simple synchronous CPU register bus. Each port owns a data register, a per-pin direction register and a control register. The data and direction registers of a port share one bus offset, and a select bit in that port's control register decides which of the two the offset reaches. Pins whose direction bit is set are driven from the data register. Pins whose direction bit is clear are inputs, and their level is read back through the data offset.

Each port has an event input with rising-edge detection. A detected edge raises the port's status flag. A small two-state machine per port keeps the flag: `FLG_QUIET` moves to `FLG_RAISED` on a detected rising edge, and `FLG_RAISED` moves back to `FLG_QUIET` when the CPU reads that port's data register. When a clearing read and a new edge fall in the same cycle, the machine stays in `FLG_RAISED`. In every other case the state holds. The interrupt output is the OR over both ports of flag AND enable.

Bit 3 of each control register drives one dedicated peripheral line. On port A it is an active-low motor line. On port B it is a command-identification line.

Top module: `periph_port_adapter`

## Requirements
- R1: Bus offsets are 0 = port A data/direction, 1 = port B data/direction, 2 = port A control, 3 = port B control.
- R2: Control bit 2 routes the port's data offset. When it is 1, reads and writes reach the data register. When it is 0, they reach the direction register.
- R3: Each port's output-enable bus equals its direction register, and its output bus equals its data register.
- R4: A read of the data register returns, for each pin, the data register bit where the direction bit is 1 and the input pin level where it is 0.
- R5: Control bit 0 enables the port's interrupt. `irq` is 1 exactly when some port has its status flag and its enable both set.
- R6: A rising edge on a port's event input sets control bit 7 (status flag) one clock later. An input held high does not set the flag again after it has been cleared.
- R7: A read of a port's data register (control bit 2 = 1) clears that port's flag. Reads of the direction register or the control register leave the flag set. A rising edge in the same cycle as the clearing read wins, and the flag stays set.
- R8: Control bit 3 of port A drives `motor_n` (0 = motor on). Control bit 3 of port B drives `cmd_id`.
- R9: A control read returns bits 5 and 4 as 1, bit 6 as 0, bit 7 as the flag, and bits 3..0 as written. Writes to bits 7..4 have no effect.
- R10: Reset clears the data, direction and control registers, both flags and the read data. All pins start as inputs, and `irq`, `motor_n` and `cmd_id` start at 0.
- R11: Read data is registered. It appears on `bus_rdata` after the clock edge that takes the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pa_in | input | DATA_W | Port A pin levels |
| pa_out | output | DATA_W | Port A pin drive values |
| pa_oe | output | DATA_W | Port A pin output enables |
| pb_in | input | DATA_W | Port B pin levels |
| pb_out | output | DATA_W | Port B pin drive values |
| pb_oe | output | DATA_W | Port B pin output enables |
| ev_a | input | 1 | Port A event input |
| ev_b | input | 1 | Port B event input |
| motor_n | output | 1 | Port A peripheral line, active low |
| cmd_id | output | 1 | Port B peripheral line |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the shared data offset. A wrong select polarity would hand back the direction byte where pin data is expected. A read mux that ignores direction would return stale register bits on input pins.

On the status flag, the bench checks that reads of the control register and of the direction view leave the flag alone. It also checks that an edge arriving in the same cycle as a clearing read keeps the flag set. A design that clears on any read, or lets the clear win, would drop an interrupt.

It holds an event input high after a clear to catch level-sensitive detection, which would re-raise the flag at once. It also writes ones into the fixed control bits and reads them back, to expose bits that are stored when they should be tied.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned CTL_W     = 8;
    localparam int unsigned CTL_KEEP  = 4;
    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned B_IE      = 0;
    localparam int unsigned B_SEL     = 2;
    localparam int unsigned B_LINE    = 3;
    localparam int unsigned B_FLAG    = 7;

    typedef enum logic [ADDR_W-1:0] {
        OFF_A_DATA = 2'd0,
        OFF_B_DATA = 2'd1,
        OFF_A_CTL  = 2'd2,
        OFF_B_CTL  = 2'd3
    } reg_off_e;

    typedef enum logic {
        FLG_QUIET  = 1'b0,
        FLG_RAISED = 1'b1
    } flag_state_e;
endpackage

// File: rtl/ppa_edge.sv
module ppa_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ppa_port.sv
module ppa_port
    import ppa_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_view,
    input  logic                wr_ctl,
    input  logic                rd_view,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [CTL_KEEP-1:0] ctl_wdata,
    input  logic [DATA_W-1:0]   pin_in,
    input  logic                ev,
    output logic [DATA_W-1:0]   pin_out,
    output logic [DATA_W-1:0]   pin_oe,
    output logic [DATA_W-1:0]   view_rd,
    output logic [CTL_W-1:0]    ctl_rd,
    output logic                line,
    output logic                irq_req
);
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   dir_q;
    logic [CTL_KEEP-1:0] ctl_q;
    logic [DATA_W-1:0]   pin_view;
    logic                rise;
    logic                clr;
    logic                flag;
    flag_state_e         state_q, state_d;

    ppa_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (ev),
        .rise (rise)
    );

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            ctl_q  <= '0;
        end else begin
            if (wr_view) begin
                if (ctl_q[B_SEL]) data_q <= wdata;
                else              dir_q  <= wdata;
            end
            if (wr_ctl) ctl_q <= ctl_wdata;
        end
    end

    assign clr = rd_view & ctl_q[B_SEL];

    // flag state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_QUIET;
        else        state_q <= state_d;
    end

    // flag next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_QUIET:  if (rise)          state_d = FLG_RAISED;
            FLG_RAISED: if (clr && !rise)  state_d = FLG_QUIET;
            default:                       state_d = FLG_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        flag            = (state_q == FLG_RAISED);
        pin_view        = (data_q & dir_q) | (pin_in & ~dir_q);
        view_rd         = ctl_q[B_SEL] ? pin_view : dir_q;
        ctl_rd          = '0;
        ctl_rd[CTL_KEEP-1:0] = ctl_q;
        ctl_rd[4]       = 1'b1;
        ctl_rd[5]       = 1'b1;
        ctl_rd[6]       = 1'b0;
        ctl_rd[B_FLAG]  = flag;
        pin_out         = data_q;
        pin_oe          = dir_q;
        line            = ctl_q[B_LINE];
        irq_req         = flag & ctl_q[B_IE];
    end
endmodule

// File: rtl/periph_port_adapter.sv
module periph_port_adapter
    import ppa_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic              ev_a,
    input  logic              ev_b,
    output logic              motor_n,
    output logic              cmd_id,
    output logic              irq
);
    localparam int unsigned NP = NUM_PORTS;

    logic [NP-1:0][DATA_W-1:0] pin_in_v, pin_out_v, pin_oe_v, view_v;
    logic [NP-1:0][CTL_W-1:0]  ctl_v;
    logic [NP-1:0]             ev_v, line_v, irq_v;
    logic [DATA_W-1:0]         rd_mux;
    logic                      rd_acc, wr_acc;

    assign pin_in_v = {pb_in, pa_in};
    assign ev_v     = {ev_b, ev_a};
    assign rd_acc   = bus_sel & ~bus_wr;
    assign wr_acc   = bus_sel &  bus_wr;

    for (genvar p = 0; p < NP; p++) begin : g_port
        ppa_port #(.DATA_W(DATA_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_view  (wr_acc && bus_addr == ADDR_W'(p)),
            .wr_ctl   (wr_acc && bus_addr == ADDR_W'(p + NP)),
            .rd_view  (rd_acc && bus_addr == ADDR_W'(p)),
            .wdata    (bus_wdata),
            .ctl_wdata(bus_wdata[CTL_KEEP-1:0]),
            .pin_in   (pin_in_v[p]),
            .ev       (ev_v[p]),
            .pin_out  (pin_out_v[p]),
            .pin_oe   (pin_oe_v[p]),
            .view_rd  (view_v[p]),
            .ctl_rd   (ctl_v[p]),
            .line     (line_v[p]),
            .irq_req  (irq_v[p])
        );
    end

    always_comb begin
        rd_mux = '0;
        unique case (reg_off_e'(bus_addr))
            OFF_A_DATA: rd_mux = view_v[0];
            OFF_B_DATA: rd_mux = view_v[1];
            OFF_A_CTL:  rd_mux[CTL_W-1:0] = ctl_v[0];
            OFF_B_CTL:  rd_mux[CTL_W-1:0] = ctl_v[1];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_mux;
    end

    assign pa_out  = pin_out_v[0];
    assign pa_oe   = pin_oe_v[0];
    assign pb_out  = pin_out_v[1];
    assign pb_oe   = pin_oe_v[1];
    assign motor_n = line_v[0];
    assign cmd_id  = line_v[1];
    assign irq     = |irq_v;
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              wbit3,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ev_a,
    input logic [DATA_W-1:0] pa_oe,
    input logic              motor_n,
    input logic              irq,
    input logic              a_flag,
    input logic              a_ie,
    input logic              a_sel,
    input logic              b_flag,
    input logic              b_ie
);
    p_flag_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_a) |=> a_flag);

    p_flag_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd0 && a_sel && !ev_a) |=> !a_flag);

    p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_flag && !(bus_sel && !bus_wr && bus_addr == 2'd0)) |=> a_flag);

    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((a_flag && a_ie) || (b_flag && b_ie)));

    p_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[1]) |=> (bus_rdata[6:4] == 3'b011));

    p_motor_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2) |=> (motor_n == $past(wbit3)));

    p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 2'd0) |=> $stable(pa_oe));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind periph_port_adapter ppa_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wbit3    (bus_wdata[3]),
    .bus_rdata(bus_rdata),
    .ev_a     (ev_a),
    .pa_oe    (pa_oe),
    .motor_n  (motor_n),
    .irq      (irq),
    .a_flag   (ctl_v[0][7]),
    .a_ie     (ctl_v[0][0]),
    .a_sel    (ctl_v[0][2]),
    .b_flag   (ctl_v[1][7]),
    .b_ie     (ctl_v[1][0])
);

// File: tb/tb_periph_port_adapter.sv
`timescale 1ns/100ps
module tb_periph_port_adapter;
    localparam int W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0, pa_in = '0, pb_in = '0;
    logic [W-1:0] bus_rdata, pa_out, pa_oe, pb_out, pb_oe;
    logic ev_a = 0, ev_b = 0;
    logic motor_n, cmd_id, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    periph_port_adapter #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .ev_a(ev_a), .ev_b(ev_b), .motor_n(motor_n), .cmd_id(cmd_id), .irq(irq)
    );

    typedef struct packed {
        logic       wr;
        logic [1:0] addr;
        logic [7:0] wd;
        logic [7:0] pin_a;
        logic [7:0] pin_b;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd2, 8'h00, 8'h00, 8'h00, 1'b1, 8'h30}, // R9 reset ctl view
        '{1'b1, 2'd0, 8'h0F, 8'h00, 8'h00, 1'b0, 8'h00}, // direction A
        '{1'b1, 2'd2, 8'h04, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b1, 2'd0, 8'hA5, 8'h00, 8'h00, 1'b0, 8'h00}, // data A
        '{1'b0, 2'd0, 8'h00, 8'h3C, 8'h00, 1'b1, 8'h35}, // R4 mixed pins
        '{1'b0, 2'd2, 8'h00, 8'h00, 8'h00, 1'b1, 8'h34}, // R9
        '{1'b1, 2'd2, 8'hF4, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b0, 2'd2, 8'h00, 8'h00, 8'h00, 1'b1, 8'h34}, // R9 upper ignored
        '{1'b1, 2'd3, 8'h04, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b1, 2'd1, 8'h77, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b0, 2'd1, 8'h00, 8'h00, 8'hC3, 1'b1, 8'hC3}, // R4 all inputs
        '{1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00}, // R2 direction view
        '{1'b1, 2'd1, 8'hFF, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 1'b1, 8'hFF}, // R2
        '{1'b1, 2'd3, 8'h04, 8'h00, 8'h00, 1'b0, 8'h00},
        '{1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 1'b1, 8'h77}, // R1 R2 data kept
        '{1'b0, 2'd0, 8'h00, 8'hFF, 8'h00, 1'b1, 8'hF5}  // R1 R4
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [1:0] addr, input logic [7:0] wd);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10 reset state
        check(bus_rdata, 0, "R10 rdata");
        check(pa_oe, 0, "R10 pa_oe");
        check(pb_oe, 0, "R10 pb_oe");
        check(irq, 0, "R10 irq");
        check(motor_n, 0, "R10 motor_n");
        check(cmd_id, 0, "R10 cmd_id");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pa_in = VEC[i].pin_a; pb_in = VEC[i].pin_b;
            bus(VEC[i].wr, VEC[i].addr, VEC[i].wd);
            if (VEC[i].chk) check(bus_rdata, VEC[i].exp, $sformatf("R1/R2/R4/R9 vector %0d", i));
        end

        check(pa_oe, 8'h0F, "R3 pa_oe");
        check(pa_out, 8'hA5, "R3 pa_out");
        check(pb_oe, 8'hFF, "R3 pb_oe");
        check(pb_out, 8'h77, "R3 pb_out");

        // R8 peripheral lines
        bus(1, 2'd2, 8'h0C); check(motor_n, 1, "R8 motor_n high");
        bus(1, 2'd3, 8'h0C); check(cmd_id, 1, "R8 cmd_id high");
        bus(1, 2'd2, 8'h04); check(motor_n, 0, "R8 motor_n low");
        check(cmd_id, 1, "R8 cmd_id kept");

        // R6 / R5 event on port A, enable off
        pa_in = 8'h00;
        @(negedge clk) ev_a = 1'b1;
        idle(1);
        check(irq, 0, "R5 irq masked");
        bus(0, 2'd2, 8'h00); check(bus_rdata, 8'hB4, "R6 flag set");
        bus(1, 2'd2, 8'h05); check(irq, 1, "R5 irq enabled");
        bus(0, 2'd2, 8'h00); check(bus_rdata, 8'hB5, "R7 ctl read");
        check(irq, 1, "R7 ctl read keeps flag");
        bus(1, 2'd2, 8'h01);
        bus(0, 2'd0, 8'h00); check(bus_rdata, 8'h0F, "R7 direction view");
        check(irq, 1, "R7 direction read keeps flag");
        bus(1, 2'd2, 8'h05);
        bus(0, 2'd0, 8'h00); check(bus_rdata, 8'h05, "R7 data read");
        check(irq, 0, "R7 data read clears");
        idle(3);
        check(irq, 0, "R6 held level no re-set");

        // R7 coincident edge and clearing read
        @(negedge clk) ev_a = 1'b0;
        @(negedge clk);
        ev_a = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
        @(posedge clk);
        @(negedge clk) bus_sel = 1'b0;
        check(irq, 1, "R7 edge wins over clear");
        bus(0, 2'd0, 8'h00);
        check(irq, 0, "R7 clear after coincident");

        // R5 port B
        @(negedge clk) ev_b = 1'b1;
        idle(1);
        check(irq, 0, "R5 port B masked");
        bus(1, 2'd3, 8'h05); check(irq, 1, "R5 port B enabled");
        bus(0, 2'd1, 8'h00); check(irq, 0, "R7 port B data read clears");

        // R11 read data holds
        bus(0, 2'd2, 8'h00); check(bus_rdata, 8'h35, "R11 ctl read");
        idle(2);
        bus(1, 2'd3, 8'h04);
        check(bus_rdata, 8'h35, "R11 rdata held");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule